// File: doc/BRIEF.md
# Motor Stop-and-Sleep Sequencer

This block decides when a brushless motor controller may drive its motor, when it goes to sleep and when it reloads its configuration. It watches three inputs: an enable pin, a reset pin and an enable-polarity bit. A shutdown begins when the enable input stays inactive for long enough, or when the polarity bit changes. The drive is then switched off, with the outputs either braking or coasting as a brake-mode input selects. The block then waits for the speed-feedback pulse to go quiet. After a fixed quiet time it raises the power-down output, which turns off the regulator, the power switch and the internal clocks.

A reset request that arrives while the motor runs also stops the drive and waits for the same quiet time. It then gives one-cycle pulses that request a configuration reload, a fault clear and a datapath initialisation. The drive stays off for as long as the reset pin is held. A reset that arrives after a shutdown has begun is kept pending and is carried out when the part wakes. Once a shutdown has begun it always runs to the end, whatever the enable pin does in the meantime.

All inputs are taken to be synchronous to `clk`. Both time windows are parameters counted in clock cycles. At 50 MHz the defaults are one second of quiet time and a 1.2 µs deassertion filter.

Top module: `motor_sleep_seq`

## Requirements
- R1: Enable is active when `en_pin ^ en_inv` is 1. After `rst_n` is released with enable active, `drive_off`, `pwr_down`, `reload_req`, `fault_clr` and `dp_init` are all 0.
- R2: A shutdown begins only when enable has been inactive for FILT_CYC consecutive cycles. The drive turns off on the clock edge that samples the FILT_CYC-th inactive cycle. A shorter inactive stretch has no effect.
- R3: While running, a change of `en_inv` starts a shutdown even when the effective enable stays active.
- R4: While stopping, or while waiting out a reset, `drive_off` is 1 and `brake_sel` follows `brake_mode`. During sleep `brake_sel` is 0.
- R5: Sleep (`pwr_down`=1) begins QUIET_CYC clock edges after the later of two events: entry into the shutdown, or the last edge that saw a transition on `fb_pulse`. A transition restarts the count.
- R6: A started shutdown runs to sleep even if enable comes back at once. The clock edge after sleep begins, an active enable wakes the block and `drive_off` returns to 0.
- R7: While enable is inactive, sleep holds with `pwr_down`=1 and `drive_off`=1.
- R8: A `rst_pin` high seen during a shutdown or during sleep is latched without producing any pulse. On wake, `reload_req`, `fault_clr` and `dp_init` pulse high for exactly one cycle.
- R9: `rst_pin` high while running turns the drive off at once. QUIET_CYC quiet edges later, the three request outputs pulse for one cycle. `drive_off` stays 1 until `rst_pin` goes low.
- R10: When `rst_pin` is released after a reset, the block runs if enable is active. Otherwise it starts a shutdown that ends in sleep.
- R11: With `en_inv`=1 and both pins tied together, both pins high disables the drive and gives the reload pulses, and both pins low lets the motor run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| en_pin | input | 1 | Enable pin before polarity correction |
| en_inv | input | 1 | Enable polarity: 1 makes the pin active low |
| rst_pin | input | 1 | Reset request pin, active high |
| brake_mode | input | 1 | 1 brakes while stopping, 0 coasts |
| fb_pulse | input | 1 | Speed-feedback pulse from the motor |
| drive_off | output | 1 | Motor drive disabled |
| brake_sel | output | 1 | Brake the motor while the drive is off |
| pwr_down | output | 1 | Turn off the regulator, the power switch and the clocks |
| reload_req | output | 1 | One-cycle configuration reload request |
| fault_clr | output | 1 | One-cycle fault clear |
| dp_init | output | 1 | One-cycle datapath initialisation |

## Verification
The hardest case to reach is a reset that is latched part-way through a shutdown, because it must stay invisible until the block wakes. The bench starts a shutdown and pulses `rst_pin` for one cycle in the middle of the quiet wait. It then checks that the entry into sleep shows no request pulse. Finally it restores enable and checks that the three requests appear exactly once. A second hard case is a feedback transition that lands a few cycles before the quiet time would expire. The bench confirms that the old deadline passes without sleep and that the new deadline brings sleep exactly on time.

// File: rtl/motor_sleep_seq.sv
module motor_sleep_seq #(
  parameter int QUIET_CYC = 50_000_000,
  parameter int FILT_CYC  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  input  logic en_inv,
  input  logic rst_pin,
  input  logic brake_mode,
  input  logic fb_pulse,
  output logic drive_off,
  output logic brake_sel,
  output logic pwr_down,
  output logic reload_req,
  output logic fault_clr,
  output logic dp_init
);
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam int FW = $clog2(FILT_CYC + 1);

  typedef enum logic [2:0] {S_RUN, S_STOP, S_SLEEP, S_RWAIT, S_RHOLD} st_t;

  st_t           st, st_nx;
  logic [QW-1:0] qcnt;
  logic [FW-1:0] fcnt;
  logic          fb_q, inv_q, inv_vld, pend, init_p;

  wire en_act    = en_pin ^ en_inv;
  wire fb_edge   = fb_pulse ^ fb_q;
  wire pol_chg   = inv_vld & (en_inv ^ inv_q);
  wire dis_hit   = !en_act && (fcnt == FW'(FILT_CYC - 1));
  wire quiet_hit = !fb_edge && (qcnt == QW'(QUIET_CYC - 1));
  wire wake      = (st == S_SLEEP) && en_act;
  wire apply_rst = wake && (pend || rst_pin);
  wire waiting   = (st == S_STOP) || (st == S_RWAIT);

  always_comb begin
    st_nx = st;
    case (st)
      S_RUN:   if (rst_pin) st_nx = S_RWAIT;
               else if (dis_hit || pol_chg) st_nx = S_STOP;
      S_STOP:  if (quiet_hit) st_nx = S_SLEEP;
      S_SLEEP: if (en_act) st_nx = rst_pin ? S_RHOLD : S_RUN;
      S_RWAIT: if (quiet_hit) st_nx = S_RHOLD;
      S_RHOLD: if (!rst_pin) st_nx = en_act ? S_RUN : S_STOP;
      default: st_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      qcnt    <= '0;
      fcnt    <= '0;
      fb_q    <= 1'b0;
      inv_q   <= 1'b0;
      inv_vld <= 1'b0;
      pend    <= 1'b0;
      init_p  <= 1'b0;
    end else begin
      st      <= st_nx;
      fb_q    <= fb_pulse;
      inv_q   <= en_inv;
      inv_vld <= 1'b1;
      init_p  <= ((st == S_RWAIT) && quiet_hit) || apply_rst;

      if (waiting) qcnt <= fb_edge ? '0 : qcnt + 1'b1;
      else         qcnt <= '0;

      if ((st == S_RUN) && !en_act) fcnt <= dis_hit ? fcnt : fcnt + 1'b1;
      else                          fcnt <= '0;

      if (wake)                                                pend <= 1'b0;
      else if (((st == S_STOP) || (st == S_SLEEP)) && rst_pin) pend <= 1'b1;
    end
  end

  assign drive_off  = (st != S_RUN);
  assign pwr_down   = (st == S_SLEEP);
  assign brake_sel  = brake_mode && drive_off && !pwr_down;
  assign reload_req = init_p;
  assign fault_clr  = init_p;
  assign dp_init    = init_p;
endmodule

module motor_sleep_seq_chk #(
  parameter int QUIET_CYC = 50_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic en_pin,
  input logic en_inv,
  input logic rst_pin,
  input logic fb_pulse,
  input logic drive_off,
  input logic brake_sel,
  input logic pwr_down,
  input logic reload_req
);
  localparam int QW = $clog2(QUIET_CYC + 1);
  logic [QW-1:0] still;
  logic          fb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      still   <= '0;
      fb_prev <= 1'b0;
    end else begin
      fb_prev <= fb_pulse;
      if (!drive_off || (fb_pulse != fb_prev)) still <= '0;
      else if (still != QW'(QUIET_CYC))        still <= still + 1'b1;
    end
  end

  assert_quiet_before_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> (still >= QW'(QUIET_CYC)));
  assert_sleep_drive_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (drive_off && !brake_sel));
  assert_sleep_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && !(en_pin ^ en_inv)) |=> pwr_down);
  assert_wake_on_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> $past(en_pin ^ en_inv));
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> !reload_req);
  assert_reset_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pin && !pwr_down) |=> drive_off);
endmodule

bind motor_sleep_seq motor_sleep_seq_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_inv(en_inv), .rst_pin(rst_pin),
  .fb_pulse(fb_pulse), .drive_off(drive_off), .brake_sel(brake_sel),
  .pwr_down(pwr_down), .reload_req(reload_req)
);

// File: tb/tb_motor_sleep_seq.sv
module tb_motor_sleep_seq;
  localparam int CLK_PERIOD = 10;
  localparam int QUIET = 40;
  localparam int FILT  = 6;
  localparam int NV = 4;
  localparam int GLEN [NV] = '{1, 5, 6, 9};
  localparam int GBRK [NV] = '{0, 1, 1, 0};
  localparam int GEXP [NV] = '{0, 0, 1, 1};

  logic clk = 0, rst_n = 0;
  logic en_pin = 1, en_inv = 0, rst_pin = 0, brake_mode = 0, fb_pulse = 0;
  logic drive_off, brake_sel, pwr_down, reload_req, fault_clr, dp_init;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_sleep_seq #(.QUIET_CYC(QUIET), .FILT_CYC(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_inv(en_inv), .rst_pin(rst_pin),
    .brake_mode(brake_mode), .fb_pulse(fb_pulse), .drive_off(drive_off),
    .brake_sel(brake_sel), .pwr_down(pwr_down), .reload_req(reload_req),
    .fault_clr(fault_clr), .dp_init(dp_init)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic inv, input logic enp);
    @(negedge clk);
    rst_n = 0; en_inv = inv; en_pin = enp; rst_pin = 0; fb_pulse = 0; brake_mode = 0;
    tick(2);
    rst_n = 1;
    tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(0, 1);
    chk("R1 drive_off", drive_off, 0);
    chk("R1 pwr_down", pwr_down, 0);
    chk("R1 reload_req", reload_req, 0);
    chk("R1 fault_clr", fault_clr, 0);
    chk("R1 dp_init", dp_init, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset(0, 1);
      brake_mode = GBRK[i][0];
      en_pin = 0;
      tick(GLEN[i]);
      en_pin = 1;
      chk("R2 filter", drive_off, GEXP[i][0]);
      if (GEXP[i] != 0) begin
        chk("R4 brake_sel", brake_sel, GBRK[i][0]);
        tick(QUIET - (GLEN[i] - FILT) - 1);
        chk("R6 no early sleep", pwr_down, 0);
        tick(1);
        chk("R6 completes", pwr_down, 1);
        chk("R4 sleep brake", brake_sel, 0);
        tick(1);
        chk("R6 wake drive", drive_off, 0);
        chk("R6 wake pwr", pwr_down, 0);
        chk("R8 no pulse", reload_req, 0);
      end else begin
        tick(QUIET + 5);
        chk("R2 ignored drive", drive_off, 0);
        chk("R2 ignored pwr", pwr_down, 0);
      end
    end

    // R5: feedback transition restarts the quiet count
    do_reset(0, 1);
    brake_mode = 1;
    en_pin = 0;
    tick(FILT);
    chk("R4 brake stop", brake_sel, 1);
    tick(QUIET - 5);
    fb_pulse = 1;
    tick(1);
    tick(QUIET - 1);
    chk("R5 restarted", pwr_down, 0);
    tick(1);
    chk("R5 sleep", pwr_down, 1);
    tick(5);
    chk("R7 hold pwr", pwr_down, 1);
    chk("R7 hold drive", drive_off, 1);
    chk("R4 sleep no brake", brake_sel, 0);

    // R8: reset during stopping is latched
    do_reset(0, 1);
    en_pin = 0;
    tick(FILT);
    tick(3);
    rst_pin = 1;
    tick(1);
    rst_pin = 0;
    tick(QUIET - 5);
    chk("R8 before sleep", pwr_down, 0);
    chk("R8 no pulse wait", reload_req, 0);
    tick(1);
    chk("R8 sleep", pwr_down, 1);
    chk("R8 no pulse sleep", reload_req, 0);
    tick(5);
    chk("R8 still pending", reload_req, 0);
    en_pin = 1;
    tick(1);
    chk("R8 reload", reload_req, 1);
    chk("R8 fault", fault_clr, 1);
    chk("R8 init", dp_init, 1);
    chk("R8 running", drive_off, 0);
    tick(1);
    chk("R8 one cycle", reload_req, 0);

    // R9: reset while running
    do_reset(0, 1);
    rst_pin = 1;
    tick(1);
    chk("R9 stop", drive_off, 1);
    chk("R9 coast", brake_sel, 0);
    tick(QUIET - 1);
    chk("R9 wait", reload_req, 0);
    tick(1);
    chk("R9 reload", reload_req, 1);
    chk("R9 fault", fault_clr, 1);
    chk("R9 init", dp_init, 1);
    tick(1);
    chk("R9 one cycle", reload_req, 0);
    tick(5);
    chk("R9 held", drive_off, 1);
    chk("R9 no sleep", pwr_down, 0);
    rst_pin = 0;
    tick(1);
    chk("R10 run", drive_off, 0);

    // R10: release with enable inactive
    rst_pin = 1;
    tick(QUIET + 3);
    rst_pin = 0; en_pin = 0;
    tick(1);
    chk("R10 stopping", drive_off, 1);
    tick(QUIET - 1);
    chk("R10 not yet", pwr_down, 0);
    tick(1);
    chk("R10 sleep", pwr_down, 1);

    // R3: polarity change
    do_reset(0, 1);
    en_inv = 1; en_pin = 0;
    tick(1);
    chk("R3 stop", drive_off, 1);
    tick(QUIET - 1);
    chk("R3 no sleep", pwr_down, 0);
    tick(1);
    chk("R3 sleep", pwr_down, 1);
    tick(1);
    chk("R3 wake", drive_off, 0);

    // R11: tied pins, active-low enable
    do_reset(1, 0);
    chk("R11 run low", drive_off, 0);
    en_pin = 1; rst_pin = 1;
    tick(1);
    chk("R11 off high", drive_off, 1);
    tick(QUIET);
    chk("R11 reload", reload_req, 1);
    tick(3);
    chk("R11 held", drive_off, 1);
    en_pin = 0; rst_pin = 0;
    tick(1);
    chk("R11 run again", drive_off, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule